// File: doc/BRIEF.md
# Column-Strobed Matrix Display Refresher

This block keeps a four-character 5x7 LED module lit without help from software. The module holds a 28-bit serial-in, parallel-out row register whose outputs sink the row currents. Its five column lines are shared by all four characters. For each column in turn, the refresher shifts that column's 28 row bits into the module over a serial clock and data pair. It then raises that column's enable for a fixed on-time. During the on-time it pulse-width modulates the row-enable (blanking) line to set the brightness.

A host loads pixels through a one-cycle write port. Each write names a character, a column and a 7-bit row pattern. The write lands in a shadow copy of the picture. The shadow copy is moved into the displayed copy only when a new frame begins, so a frame never mixes old and new pixels.

The serial clock runs at the system clock divided by `2*HALF_DIV`. With a 50 MHz system clock and the default divider it stays below 3 MHz, with at least 160 ns per phase. Each column slot lasts `56*HALF_DIV + ON_CYCLES` system cycles. The defaults keep each slot well under the 2 ms that a 100 Hz refresh of every column allows.

Top module: `matrix_strobe_driver`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ser_clk`, `ser_data`, `row_en` and all of `col_en` are low.
- R2: During a load, every high phase and every low phase of `ser_clk` lasts exactly `HALF_DIV` system cycles, and the first rise comes `HALF_DIV` cycles after the load starts. `ser_data` changes only in the cycle in which `ser_clk` rises, so it is steady around every falling edge.
- R3: Each load delivers 28 bits, one per falling edge of `ser_clk`. The first seven are the rows of character 3 (`wr_char`=3), from row bit 6 down to row bit 0. Characters 2, 1 and 0 follow in the same way. Each bit goes out exactly as written: 1 lights the LED.
- R4: All of `col_en` stays low for the `56*HALF_DIV` cycles of a load. The enable rises in the cycle of the 28th falling edge of `ser_clk`. At most one bit of `col_en` is ever high, and it stays high, unchanged, for exactly `ON_CYCLES` cycles. The next load begins as soon as it falls.
- R5: The columns are lit in the order `col_en[0]`, `col_en[1]`, ..., `col_en[4]`, and the order then repeats.
- R6: `row_en` is low whenever `col_en` is all low. In on-cycle k (k = 0 in the first cycle of the enable), `row_en` equals `((k / PWM_DIV) mod 15) < L`, where L is the latched 4-bit level. L = 0 keeps the rows dark, and L = 15 keeps them on for the whole on-time.
- R7: L is taken from `level` on the clock edge that raises the column enable. A change of `level` during an on-time has no effect until the next column.
- R8: A write (`wr_en`=1) stores `wr_rows` for character `wr_char` (0..3) and column `wr_col` (0..4), with bit r driving row r+1, in a shadow copy. The displayed copy takes the whole shadow copy on the edge where `col_en[4]` falls. A write is therefore never seen partway through a frame.
- R9: A write accepted on the same edge as that copy is held in the shadow copy and appears one frame later.
- R10: A write with `wr_col` of 5, 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Pixel write strobe |
| wr_char | input | 2 | Character index of the write |
| wr_col | input | 3 | Column index of the write (0..4 valid) |
| wr_rows | input | 7 | Row pattern; bit r drives row r+1 |
| level | input | 4 | Brightness level, latched per column |
| ser_clk | output | 1 | Serial clock; the module shifts on its falling edge |
| ser_data | output | 1 | Serial row data |
| col_en | output | 5 | One-hot column enables |
| row_en | output | 1 | Row-driver enable, PWM during the on-time |

## Verification
Two events can meet on one clock edge: a pixel write and the frame-start copy of the shadow picture into the displayed picture. The bench provokes this by counting the on-cycles of column 4 from the rise of its enable. It drives the write in the last of them, so the write is sampled on the very edge where `col_en[4]` falls. The next frame must still show the old pattern in every column, and only the frame after it may show the new one. The same counting places a `level` change in the middle of an on-time, so the brightness latch is judged against a change that falls mid-column.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

    localparam int NCHAR     = 4;
    localparam int NCOL      = 5;
    localparam int NROW      = 7;
    localparam int LVL_W     = 4;

    localparam int CHAIN     = NCHAR * NROW;
    localparam int CHAR_W    = $clog2(NCHAR);
    localparam int COL_W     = $clog2(NCOL);
    localparam int BIT_W     = $clog2(CHAIN);
    localparam int PWM_STEPS = (1 << LVL_W) - 1;

    typedef logic [NROW-1:0] rows_t;

    // one column of the displayed picture, character-major, row bit 6 highest
    typedef logic [NCHAR-1:0][NROW-1:0] slice_t;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_LIT  = 1'b1
    } phase_e;

    typedef struct packed {
        logic              en;
        logic [CHAR_W-1:0] chr;
        logic [COL_W-1:0]  col;
        rows_t             rows;
    } pix_wr_t;

    function automatic logic [NCOL-1:0] col_select(input logic [COL_W-1:0] idx);
        logic [NCOL-1:0] sel;
        sel = '0;
        for (int i = 0; i < NCOL; i++) begin
            if (idx == COL_W'(i)) sel[i] = 1'b1;
        end
        return sel;
    endfunction

endpackage

// File: rtl/frame_store.sv
module frame_store
    import strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pix_wr_t           wr,
    input  logic              swap,
    input  logic [COL_W-1:0]  rd_col,
    output slice_t            slice
);

    rows_t shadow [NCHAR][NCOL];
    rows_t shown  [NCHAR][NCOL];

    // host side: writes to out-of-range columns match no entry
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCHAR; c++) begin
                for (int k = 0; k < NCOL; k++) begin
                    shadow[c][k] <= '0;
                end
            end
        end else if (wr.en) begin
            for (int c = 0; c < NCHAR; c++) begin
                for (int k = 0; k < NCOL; k++) begin
                    if (wr.chr == CHAR_W'(c) && wr.col == COL_W'(k)) begin
                        shadow[c][k] <= wr.rows;
                    end
                end
            end
        end
    end

    // display side: whole picture replaced at frame start only
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCHAR; c++) begin
                for (int k = 0; k < NCOL; k++) begin
                    shown[c][k] <= '0;
                end
            end
        end else if (swap) begin
            for (int c = 0; c < NCHAR; c++) begin
                for (int k = 0; k < NCOL; k++) begin
                    shown[c][k] <= shadow[c][k];
                end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCHAR; c++) begin
            slice[c] = '0;
            for (int k = 0; k < NCOL; k++) begin
                if (rd_col == COL_W'(k)) slice[c] = shown[c][k];
            end
        end
    end

endmodule

// File: rtl/serial_loader.sv
module serial_loader
    import strobe_pkg::*;
#(
    parameter int HALF_DIV = 9
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  slice_t slice,
    output logic   sclk,
    output logic   sdata,
    output logic   done
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [BIT_W-1:0] TOP_IDX = BIT_W'(CHAIN - 1);

    logic [DIV_W-1:0] div_q;
    logic [BIT_W-1:0] idx_q;
    logic [CHAIN-1:0] flat;
    logic             tick;

    // bit 27 of flat is character 3 row bit 6: shifted first so it ends deepest
    assign flat = slice;
    assign tick = (div_q == DIV_W'(HALF_DIV - 1));
    assign done = run && tick && sclk && (idx_q == TOP_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            idx_q <= '0;
            sclk  <= 1'b0;
            sdata <= 1'b0;
        end else if (!run) begin
            div_q <= '0;
            idx_q <= '0;
            sclk  <= 1'b0;
        end else if (tick) begin
            div_q <= '0;
            if (!sclk) begin
                // data moves with the rising edge, half a period before the sample
                sclk  <= 1'b1;
                sdata <= flat[TOP_IDX - idx_q];
            end else begin
                sclk  <= 1'b0;
                idx_q <= done ? '0 : idx_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
    import strobe_pkg::*;
#(
    parameter int ON_CYCLES = 20000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_done,
    output phase_e           phase,
    output logic [COL_W-1:0] col,
    output logic             swap
);

    localparam int ON_W = (ON_CYCLES > 1) ? $clog2(ON_CYCLES) : 1;

    logic [ON_W-1:0] on_q;
    logic            on_end;
    logic            last_col;

    assign on_end   = (phase == PH_LIT) && (on_q == ON_W'(ON_CYCLES - 1));
    assign last_col = (col == COL_W'(NCOL - 1));
    assign swap     = on_end && last_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOAD;
            col   <= '0;
            on_q  <= '0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    on_q <= '0;
                    if (load_done) phase <= PH_LIT;
                end
                PH_LIT: begin
                    if (on_end) begin
                        phase <= PH_LOAD;
                        on_q  <= '0;
                        col   <= last_col ? '0 : col + 1'b1;
                    end else begin
                        on_q <= on_q + 1'b1;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/pwm_dimmer.sv
module pwm_dimmer
    import strobe_pkg::*;
#(
    parameter int PWM_DIV = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             lit,
    input  logic [LVL_W-1:0] level_in,
    output logic             row_en
);

    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] step_q;
    logic             adv;

    generate
        if (PWM_DIV <= 1) begin : g_nodiv
            assign adv = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(PWM_DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || start) begin
                    pre_q <= '0;
                end else if (lit) begin
                    pre_q <= (pre_q == PW'(PWM_DIV - 1)) ? '0 : pre_q + 1'b1;
                end
            end
            assign adv = (pre_q == PW'(PWM_DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            step_q <= '0;
        end else if (start) begin
            lvl_q  <= level_in;
            step_q <= '0;
        end else if (lit && adv) begin
            step_q <= (step_q == LVL_W'(PWM_STEPS - 1)) ? '0 : step_q + 1'b1;
        end
    end

    assign row_en = lit && (step_q < lvl_q);

endmodule

// File: rtl/matrix_strobe_driver.sv
module matrix_strobe_driver
    import strobe_pkg::*;
#(
    parameter int HALF_DIV  = 9,
    parameter int ON_CYCLES = 20000,
    parameter int PWM_DIV   = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic [COL_W-1:0] wr_col,
    input  logic [NROW-1:0]  wr_rows,
    input  logic [LVL_W-1:0] level,
    output logic             ser_clk,
    output logic             ser_data,
    output logic [NCOL-1:0]  col_en,
    output logic             row_en
);

    pix_wr_t          wr_req;
    phase_e           phase;
    logic [COL_W-1:0] col;
    logic             swap;
    logic             load_done;
    slice_t           slice;
    logic             lit;

    assign wr_req.en   = wr_en;
    assign wr_req.chr  = wr_char;
    assign wr_req.col  = wr_col;
    assign wr_req.rows = wr_rows;

    assign lit    = (phase == PH_LIT);
    assign col_en = lit ? col_select(col) : '0;

    frame_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .swap   (swap),
        .rd_col (col),
        .slice  (slice)
    );

    serial_loader #(.HALF_DIV(HALF_DIV)) u_load (
        .clk   (clk),
        .rst   (rst),
        .run   (!lit),
        .slice (slice),
        .sclk  (ser_clk),
        .sdata (ser_data),
        .done  (load_done)
    );

    strobe_seq #(.ON_CYCLES(ON_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load_done (load_done),
        .phase     (phase),
        .col       (col),
        .swap      (swap)
    );

    pwm_dimmer #(.PWM_DIV(PWM_DIV)) u_pwm (
        .clk      (clk),
        .rst      (rst),
        .start    (load_done),
        .lit      (lit),
        .level_in (level),
        .row_en   (row_en)
    );

endmodule

// File: rtl/strobe_checker.sv
module strobe_checker
    import strobe_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ser_clk,
    input logic            ser_data,
    input logic [NCOL-1:0] col_en,
    input logic            row_en
);

    // R4: no column lit while a serial pulse is high
    a_r4_dark_during_shift: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> (col_en == '0))
        else $error("column lit during serial pulse");

    // R4: never more than one column
    a_r4_single_column: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_en))
        else $error("several columns lit");

    // R4: a lit column holds until it goes dark
    a_r4_column_held: assert property (@(posedge clk) disable iff (rst)
        ((col_en != '0) && ($past(col_en) != '0)) |-> $stable(col_en))
        else $error("column changed without going dark");

    // R2: data only moves together with a rising serial clock
    a_r2_data_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> $rose(ser_clk))
        else $error("serial data moved off the rising edge");

    // R6: rows enabled only while a column is lit
    a_r6_rows_dark_when_idle: assert property (@(posedge clk) disable iff (rst)
        row_en |-> (col_en != '0))
        else $error("row enable outside on-time");

endmodule

bind matrix_strobe_driver strobe_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .col_en   (col_en),
    .row_en   (row_en)
);

// File: tb/matrix_strobe_driver_test.sv
module matrix_strobe_driver_test;

    localparam int H   = 2;
    localparam int ONC = 40;
    localparam int PD  = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_char;
    logic [2:0] wr_col;
    logic [6:0] wr_rows;
    logic [3:0] level;
    wire        ser_clk;
    wire        ser_data;
    wire  [4:0] col_en;
    wire        row_en;

    int n_checks = 0;
    int n_fail   = 0;
    logic [6:0] exp_active [4][5];

    always #10 clk = ~clk;

    matrix_strobe_driver #(.HALF_DIV(H), .ON_CYCLES(ONC), .PWM_DIV(PD)) uut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_char  (wr_char),
        .wr_col   (wr_col),
        .wr_rows  (wr_rows),
        .level    (level),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .col_en   (col_en),
        .row_en   (row_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [6:0] pat(input int ch, input int cl);
        return 7'((ch * 5 + cl) * 37 + 11);
    endfunction

    task automatic do_write(input int ch, input int cl, input logic [6:0] v);
        wr_en = 1'b1; wr_char = 2'(ch); wr_col = 3'(cl); wr_rows = v;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    // leaves the bench at the first sample of a column-0 load
    task automatic sync_frame();
        while (col_en[4] !== 1'b1) @(negedge clk);
        while (col_en !== 5'b0) @(negedge clk);
    endtask

    // entered at the first (unprocessed) sample of a load; leaves at the next one
    task automatic capture_column(input int exp_col, input int lvl_set,
                                  input int chg_at, input int chg_val,
                                  input int wr_at, input int wch, input int wcl,
                                  input int wrw);
        int nf = 0, run = 0, load_len = 0, on_k = 0, col = -1, lvl = 0;
        int terr = 0, perr = 0, enerr = 0;
        bit seen = 0, first = 1, fall_at_on = 0;
        logic prev_clk = 1'b0, prev_dat = 1'b0;
        logic [27:0] got = '0, expv = '0;
        if (lvl_set >= 0) level = 4'(lvl_set);
        forever begin
            bit rise, fall;
            wr_en = 1'b0;
            if (seen && col_en === 5'b0) break;
            rise = ser_clk && !prev_clk;
            fall = !ser_clk && prev_clk;
            if (ser_clk !== prev_clk) begin
                if (run != H) terr++;
                run = 1;
            end else begin
                run++;
            end
            if (fall) begin
                if (nf < 28) got[nf] = ser_data;
                nf++;
            end
            if (!first && ser_data !== prev_dat && !rise) terr++;
            if (col_en === 5'b0) begin
                load_len++;
                if (row_en !== 1'b0) perr++;
            end else begin
                if (!seen) begin
                    seen = 1;
                    lvl = int'(level);
                    fall_at_on = fall;
                    for (int i = 0; i < 5; i++) if (col_en[i]) col = i;
                end
                if (col < 0 || col_en !== (5'b1 << col)) enerr++;
                if (row_en !== ((((on_k / PD) % 15) < lvl) ? 1'b1 : 1'b0)) perr++;
                if (on_k == chg_at) level = 4'(chg_val);
                if (on_k == wr_at) begin
                    wr_en = 1'b1; wr_char = 2'(wch); wr_col = 3'(wcl); wr_rows = 7'(wrw);
                end
                on_k++;
            end
            prev_clk = ser_clk;
            prev_dat = ser_data;
            first = 0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int b = 0; b < 28; b++) expv[b] = exp_active[3 - b / 7][exp_col][6 - b % 7];
        check(col == exp_col, "R5", "column order", col, exp_col);
        check(load_len == 56 * H, "R4", "load length with columns dark", load_len, 56 * H);
        check(on_k == ONC && enerr == 0, "R4", "one-hot on-time length", on_k, ONC);
        check(nf == 28 && fall_at_on, "R4", "enable at 28th falling edge", nf, 28);
        check(terr == 0, "R2", "serial phase or data-change violations", terr, 0);
        check(got == expv, "R3", "shifted row bits", int'(got), int'(expv));
        check(perr == 0, "R6 R7", "row enable mismatches", perr, 0);
    endtask

    task automatic plain_frame(input int lvl);
        for (int c = 0; c < 5; c++) capture_column(c, lvl, -1, 0, -1, 0, 0, 0);
    endtask

    task automatic test_reset();
        rst = 1'b1; wr_en = 1'b0; wr_char = '0; wr_col = '0; wr_rows = '0; level = '0;
        repeat (3) @(negedge clk);
        check(ser_clk === 1'b0 && ser_data === 1'b0 && col_en === 5'b0 && row_en === 1'b0,
              "R1", "outputs during reset", int'({ser_clk, ser_data, col_en, row_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ser_clk === 1'b0 && ser_data === 1'b0 && col_en === 5'b0 && row_en === 1'b0,
              "R1", "outputs after reset", int'({ser_clk, ser_data, col_en, row_en}), 0);
    endtask

    task automatic test_pattern();
        for (int ch = 0; ch < 4; ch++)
            for (int cl = 0; cl < 5; cl++) do_write(ch, cl, pat(ch, cl));
        do_write(2, 3, 7'h7F);
        do_write(1, 1, 7'h00);
        sync_frame();
        for (int ch = 0; ch < 4; ch++)
            for (int cl = 0; cl < 5; cl++) exp_active[ch][cl] = pat(ch, cl);
        exp_active[2][3] = 7'h7F;
        exp_active[1][1] = 7'h00;
        plain_frame(15);  // R3 R5 at full brightness
    endtask

    task automatic test_dimming();  // R6
        capture_column(0, 0, -1, 0, -1, 0, 0, 0);
        capture_column(1, 5, -1, 0, -1, 0, 0, 0);
        capture_column(2, 7, -1, 0, -1, 0, 0, 0);
        capture_column(3, 1, -1, 0, -1, 0, 0, 0);
        capture_column(4, 14, -1, 0, -1, 0, 0, 0);
    endtask

    task automatic test_level_latch();  // R7
        capture_column(0, 9, 10, 4, -1, 0, 0, 0);
        capture_column(1, -1, -1, 0, -1, 0, 0, 0);
        check(level == 4'd4, "R7", "level carried to next column", int'(level), 4);
        capture_column(2, 15, 20, 0, -1, 0, 0, 0);
        capture_column(3, -1, -1, 0, -1, 0, 0, 0);
        capture_column(4, 12, -1, 0, -1, 0, 0, 0);
    endtask

    task automatic test_double_buffer();  // R8
        logic [6:0] nv;
        nv = ~exp_active[3][4];
        capture_column(0, 15, -1, 0, -1, 0, 0, 0);
        capture_column(1, 15, -1, 0, -1, 0, 0, 0);
        capture_column(2, 15, -1, 0, 5, 3, 4, int'(nv));
        capture_column(3, 15, -1, 0, -1, 0, 0, 0);
        capture_column(4, 15, -1, 0, -1, 0, 0, 0);  // R8 old picture still shown
        exp_active[3][4] = nv;
        plain_frame(15);                            // R8 new picture from frame start
    endtask

    task automatic test_swap_collision();  // R9
        logic [6:0] nv;
        nv = ~exp_active[1][0];
        for (int c = 0; c < 4; c++) capture_column(c, 15, -1, 0, -1, 0, 0, 0);
        capture_column(4, 15, -1, 0, ONC - 1, 1, 0, int'(nv));
        plain_frame(15);                 // R9 write missed this copy
        exp_active[1][0] = nv;
        plain_frame(15);                 // R9 shown one frame later
    endtask

    task automatic test_bad_column();  // R10
        capture_column(0, 15, -1, 0, -1, 0, 0, 0);
        capture_column(1, 15, -1, 0, 3, 1, 5, int'(~exp_active[2][0]));
        capture_column(2, 15, -1, 0, 3, 0, 7, int'(~exp_active[1][0]));
        capture_column(3, 15, -1, 0, 3, 3, 6, int'(~exp_active[0][1]));
        capture_column(4, 15, -1, 0, -1, 0, 0, 0);
        plain_frame(15);                 // R10 picture unchanged
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_pattern();
        test_dimming();
        test_level_latch();
        test_double_buffer();
        test_swap_collision();
        test_bad_column();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule